// File: doc/BRIEF.md
# Four-Channel Potentiometer Wiper Controller with I2C Slave Port

This block holds the digital control state of four 128-step potentiometers behind an I2C slave port. Each channel has a volatile 7-bit wiper code. Code 0 is the tap nearest the low terminal and code 127 is the tap nearest the high terminal. A shared control register carries an active-low shutdown bit. While shutdown is active, every channel's shutdown output is raised and the stored wiper codes are left unchanged. The analog ladder that consumes these outputs is outside this block.

The bus pins are synchronized to the system clock and sampled on it. The block detects START and STOP conditions and answers to a 7-bit slave address. The upper four bits of that address are a fixed parameter and the lower three come from pins, so up to eight devices can share one bus.

The block supports two transfers:
- A single-byte write: device byte, register byte, data byte.
- A random read: device byte, register byte, repeated START, device byte with the read bit set, then one data byte from the slave.

SDA is driven open-drain. The block only ever pulls SDA low, and only inside acknowledge slots and read-data bits.

Top module: `quad_wiper_i2c`

## Requirements
- R1: After reset every wiper output equals 64, every shutdown output is 0, and SDA is released (sda_oe_o = 0).
- R2: A write with a matching device byte (R/W bit 0) to register 0..3 is ACKed on all three bytes. The wiper of channel i takes bits 6:0 of the data byte, and bit 7 is discarded. Channel i appears on wiper_o[7*i+6 : 7*i].
- R3: The slave address is {4'b0101, addr_pins_i}, sent as bits 7:1 of the device byte with R/W in bit 0. A non-matching device byte is NACKed. After it, no byte is ACKed and no register changes until the next START.
- R4: A random read returns register content MSB first after the ACKed device-read byte. For a wiper register that content is {1'b0, wiper}. All three preceding bytes are ACKed.
- R5: Register 10h holds an active-low shutdown bit in bit 6, reset value 1. Writing 0 to it sets all shutdown outputs to 1, and writing 1 clears them. Wiper values are kept in both cases. Reading 10h returns bit 6 with all other bits 0.
- R6: A write to an address other than 0..3 and 10h is NACKed on the data byte and changes nothing. A read of such an address returns 00h.
- R7: Only one data byte is accepted per write. A second data byte is NACKed and not stored.
- R8: SDA as driven by the block changes only after an SCL falling edge, never while SCL is high.
- R9: The block never pulls SDA low during bits driven by the master. It drives only in ACK slots and read-data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| addr_pins_i | input | 3 | Low three bits of the slave address |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain enable) |
| wiper_o | output | 28 | Packed wiper codes, 7 bits per channel |
| shdn_o | output | 4 | Per-channel shutdown flag |

## Verification
The bench builds the block with its default parameters: four channels, 7-bit wipers, prefix 0101, control register at 10h and two synchronizer stages. The address pins are tied to 101. These settings make both wiper extremes (0 and 127) and the mid-scale reset value directly observable. The sparse map can be probed between the wiper block and the control address, and device bytes that differ only in the pin bits or only in the prefix bits can both be tried. Each bus bit is held for six clock cycles per quarter period, which keeps the synchronizer latency inside every SCL phase.

// File: rtl/qw_pkg.sv
package qw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_REG,
    ST_DAT,
    ST_ACK,
    ST_TX,
    ST_IGN
  } qw_state_e;
endpackage

// File: rtl/qw_bus_sync.sv
module qw_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/qw_i2c_slave.sv
module qw_i2c_slave
  import qw_pkg::*;
#(
  parameter int   PIN_W      = 3,
  parameter logic [6-PIN_W:0] DEV_PREFIX = 4'b0101
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [PIN_W-1:0] pins_i,
  input  logic [7:0]       rdata_i,
  input  logic             mapped_i,
  output logic [7:0]       ptr_o,
  output logic             we_o,
  output logic [7:0]       wdata_o,
  output logic             sda_oe_o
);
  qw_state_e  state, next_q;
  logic [3:0] cnt;
  logic [7:0] sh, tx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      next_q   <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      ptr_o    <= '0;
      we_o     <= 1'b0;
      wdata_o  <= '0;
      sda_oe_o <= 1'b0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        state    <= ST_DEV;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_DEV, ST_REG, ST_DAT: begin
            if (scl_rise_i && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (scl_fall_i && cnt == 4'd8) begin
              cnt <= '0;
              unique case (state)
                ST_DEV: begin
                  if (sh[7:1] == {DEV_PREFIX, pins_i}) begin
                    sda_oe_o <= 1'b1;
                    state    <= ST_ACK;
                    next_q   <= sh[0] ? ST_TX : ST_REG;
                  end else begin
                    state <= ST_IGN;
                  end
                end
                ST_REG: begin
                  ptr_o    <= sh;
                  sda_oe_o <= 1'b1;
                  state    <= ST_ACK;
                  next_q   <= ST_DAT;
                end
                default: begin
                  if (mapped_i) begin
                    sda_oe_o <= 1'b1;
                    we_o     <= 1'b1;
                    wdata_o  <= sh;
                    state    <= ST_ACK;
                    next_q   <= ST_IGN;
                  end else begin
                    state <= ST_IGN;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              state <= next_q;
              cnt   <= '0;
              if (next_q == ST_TX) begin
                tx       <= rdata_i;
                sda_oe_o <= ~rdata_i[7];
              end else begin
                sda_oe_o <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (cnt == 4'd7) begin
                sda_oe_o <= 1'b0;
                state    <= ST_IGN;
              end else begin
                sda_oe_o <= ~tx[6];
                tx       <= {tx[6:0], 1'b0};
                cnt      <= cnt + 4'd1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: drive only in ACK slot or read-data bits
  a_r9_drive_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (state == ST_ACK || state == ST_TX));
  // R8: drive changes follow an SCL fall (or a bus condition that releases)
  a_r8_change_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> ($past(scl_fall_i) || $past(start_i) || $past(stop_i)));
  // R7: one write strobe per transfer
  a_r7_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
  // R3: ignored transfers stay silent
  a_r3_ignore_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IGN) |-> !we_o);
endmodule

// File: rtl/qw_regfile.sv
module qw_regfile #(
  parameter int         NUM_CH    = 4,
  parameter int         WIPER_W   = 7,
  parameter logic [7:0] CTRL_ADDR = 8'h10,
  parameter int         SHDN_BIT  = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [7:0]                 addr_i,
  input  logic                       we_i,
  input  logic [7:0]                 wdata_i,
  output logic [7:0]                 rdata_o,
  output logic                       mapped_o,
  output logic [NUM_CH*WIPER_W-1:0]  wiper_o,
  output logic [NUM_CH-1:0]          shdn_o
);
  localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);

  logic [WIPER_W-1:0] wiper_q [NUM_CH];
  logic               run_n_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               wiper_q[ch] <= MID;
      else if (we_i && addr_i == 8'(ch))         wiper_q[ch] <= wdata_i[WIPER_W-1:0];
    end
    assign wiper_o[ch*WIPER_W +: WIPER_W] = wiper_q[ch];
    assign shdn_o[ch] = ~run_n_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          run_n_q <= 1'b1;
    else if (we_i && addr_i == CTRL_ADDR) run_n_q <= wdata_i[SHDN_BIT];
  end

  assign mapped_o = (addr_i < 8'(NUM_CH)) || (addr_i == CTRL_ADDR);

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr_i == 8'(i)) rdata_o = 8'(wiper_q[i]);
    if (addr_i == CTRL_ADDR) rdata_o[SHDN_BIT] = run_n_q;
  end

  // R6: writes only reach mapped registers
  a_r6_write_mapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> mapped_o);
  // R2: wipers move only on a write strobe
  a_r2_wiper_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(wiper_o));
  // R5: shutdown flags move only on a write strobe
  a_r5_shdn_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(shdn_o));
endmodule

// File: rtl/quad_wiper_i2c.sv
module quad_wiper_i2c #(
  parameter int         NUM_CH      = 4,
  parameter int         WIPER_W     = 7,
  parameter int         PIN_W       = 3,
  parameter logic [6-PIN_W:0] DEV_PREFIX = 4'b0101,
  parameter logic [7:0] CTRL_ADDR   = 8'h10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      scl_i,
  input  logic                      sda_i,
  input  logic [PIN_W-1:0]          addr_pins_i,
  output logic                      sda_oe_o,
  output logic [NUM_CH*WIPER_W-1:0] wiper_o,
  output logic [NUM_CH-1:0]         shdn_o
);
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] ptr, wdata, rdata;
  logic       we, mapped;

  qw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  qw_i2c_slave #(.PIN_W(PIN_W), .DEV_PREFIX(DEV_PREFIX)) u_slave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .pins_i     (addr_pins_i),
    .rdata_i    (rdata),
    .mapped_i   (mapped),
    .ptr_o      (ptr),
    .we_o       (we),
    .wdata_o    (wdata),
    .sda_oe_o   (sda_oe_o)
  );

  qw_regfile #(.NUM_CH(NUM_CH), .WIPER_W(WIPER_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (ptr),
    .we_i     (we),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .mapped_o (mapped),
    .wiper_o  (wiper_o),
    .shdn_o   (shdn_o)
  );
endmodule

// File: tb/quad_wiper_i2c_bench.sv
module quad_wiper_i2c_bench;
  localparam int Q = 6;
  localparam logic [6:0] DEV = {4'b0101, 3'b101};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line, sda_oe;
  logic [27:0] wiper;
  logic [3:0]  shdn;
  int checks = 0, fails = 0;
  logic [6:0] mdl_w [4];
  logic       mdl_run_n;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  quad_wiper_i2c u_quad_wiper_i2c (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_pins_i(3'b101), .sda_oe_o(sda_oe), .wiper_o(wiper), .shdn_o(shdn)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit is_mapped(input logic [7:0] r);
    return (r < 8'd4) || (r == 8'h10);
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] r);
    if (r < 8'd4) return {1'b0, mdl_w[r[1:0]]};
    if (r == 8'h10) return {1'b0, mdl_run_n, 6'b0};
    return 8'h00;
  endfunction

  task automatic bus_start;
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    scl_m = 1'b0; sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    int drove = 0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(Q);
      if (sda_oe) drove++;
      scl_m = 1'b0; tick(Q);
    end
    chk("R9 slave silent in master bits", drove, 0);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_line;
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit nack);
    int bad = 0;
    logic a, z;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(1);
      a = sda_line; tick(Q - 2);
      z = sda_line; tick(1);
      if (a !== z) bad++;
      b[i] = a;
      scl_m = 1'b0; tick(Q);
    end
    chk("R8 SDA stable while SCL high", bad, 0);
    sda_m = nack; tick(Q);
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic wr_txn(input logic [6:0] dev, input logic [7:0] r, input logic [7:0] d,
                        output bit a0, output bit a1, output bit a2);
    bus_start;
    send_byte({dev, 1'b0}, a0);
    send_byte(r, a1);
    send_byte(d, a2);
    bus_stop;
  endtask

  task automatic rd_txn(input logic [6:0] dev, input logic [7:0] r, output logic [7:0] d,
                        output bit a0, output bit a1, output bit a2);
    bus_start;
    send_byte({dev, 1'b0}, a0);
    send_byte(r, a1);
    bus_start;
    send_byte({dev, 1'b1}, a2);
    recv_byte(d, 1'b1);
    bus_stop;
  endtask

  task automatic chk_ports(input string req);
    for (int c = 0; c < 4; c++) chk(req, int'(wiper[c*7 +: 7]), int'(mdl_w[c]));
    chk(req, int'(shdn), mdl_run_n ? 0 : 15);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report;
  end

  initial begin
    bit a0, a1, a2, a3;
    logic [7:0] d;
    void'($urandom(32'd1234));
    for (int c = 0; c < 4; c++) mdl_w[c] = 7'd64;
    mdl_run_n = 1'b1;
    tick(4);
    // R1 reset state
    chk_ports("R1 reset outputs");
    chk("R1 SDA released", int'(sda_oe), 0);
    rst_n = 1'b1;
    tick(4);

    // R2 writes incl. extremes and bit 7 discard
    wr_txn(DEV, 8'd0, 8'd0, a0, a1, a2);   mdl_w[0] = 7'd0;
    chk("R2 acks", int'({a0, a1, a2}), 7);
    wr_txn(DEV, 8'd1, 8'd127, a0, a1, a2); mdl_w[1] = 7'd127;
    wr_txn(DEV, 8'd3, 8'hC5, a0, a1, a2);  mdl_w[3] = 7'h45;
    chk("R2 bit7 write acks", int'({a0, a1, a2}), 7);
    chk_ports("R2 wiper ports");

    // R4 reads
    for (int r = 0; r < 4; r++) begin
      rd_txn(DEV, 8'(r), d, a0, a1, a2);
      chk("R4 read acks", int'({a0, a1, a2}), 7);
      chk("R4 read data", int'(d), int'(exp_read(8'(r))));
    end

    // R3 wrong pin bits, then wrong prefix, with trailing bytes ignored
    wr_txn({4'b0101, 3'b100}, 8'd2, 8'd9, a0, a1, a2);
    chk("R3 pin mismatch nack", int'({a0, a1, a2}), 0);
    wr_txn({4'b1101, 3'b101}, 8'd2, 8'd9, a0, a1, a2);
    chk("R3 prefix mismatch nack", int'({a0, a1, a2}), 0);
    chk_ports("R3 no change");

    // R5 shutdown control
    wr_txn(DEV, 8'h10, 8'h00, a0, a1, a2); mdl_run_n = 1'b0;
    chk("R5 ctrl ack", int'(a2), 1);
    chk_ports("R5 shutdown asserted, wipers kept");
    rd_txn(DEV, 8'h10, d, a0, a1, a2);
    chk("R5 ctrl read", int'(d), 0);
    wr_txn(DEV, 8'h10, 8'hFF, a0, a1, a2); mdl_run_n = 1'b1;
    rd_txn(DEV, 8'h10, d, a0, a1, a2);
    chk("R5 ctrl read back", int'(d), 8'h40);
    chk_ports("R5 shutdown released");

    // R6 unmapped
    wr_txn(DEV, 8'h04, 8'h11, a0, a1, a2);
    chk("R6 unmapped data nack", int'({a0, a1, a2}), 6);
    rd_txn(DEV, 8'h0F, d, a0, a1, a2);
    chk("R6 unmapped read", int'(d), 0);
    chk_ports("R6 no change");

    // R7 second data byte
    bus_start;
    send_byte({DEV, 1'b0}, a0);
    send_byte(8'd2, a1);
    send_byte(8'd10, a2);
    send_byte(8'd99, a3);
    bus_stop;
    mdl_w[2] = 7'd10;
    chk("R7 second byte nack", int'(a3), 0);
    chk_ports("R7 first byte only");

    // random mix
    for (int n = 0; n < 40; n++) begin
      int sel = int'($urandom % 6);
      logic [7:0] r, dat;
      dat = 8'($urandom);
      if (sel < 4) r = 8'(sel);
      else if (sel == 4) r = 8'h10;
      else r = 8'h04 + 8'($urandom % 12);
      if ($urandom % 2 == 0) begin
        wr_txn(DEV, r, dat, a0, a1, a2);
        chk(is_mapped(r) ? "R2 random write ack" : "R6 random write nack",
            int'(a2), int'(is_mapped(r)));
        if (r < 8'd4) mdl_w[r[1:0]] = dat[6:0];
        else if (r == 8'h10) mdl_run_n = dat[6];
        chk_ports("R2 random ports");
      end else begin
        rd_txn(DEV, r, d, a0, a1, a2);
        chk("R4 random read", int'(d), int'(exp_read(r)));
      end
    end
    report;
  end
endmodule